// File: doc/BRIEF.md
# Synchronous Burst SRAM Model

This block is a clocked, single-port static memory model with a line-burst address sequencer. A word is 36 bits wide and is split into four 9-bit byte lanes. The default depth is 256 words. Every input is sampled on the rising clock edge. Reads are flow-through: the word at the address registered on an edge appears on `rdata` during the cycle that follows that edge.

An access can be opened by either of two start strobes. `proc_start` is meant for a processor. It is ignored unless `sel_main` is high, and it always opens a read. `ctrl_start` is meant for a second bus controller. It opens a read or a write depending on the write enables. Once an access is open, `advance` steps a 2-bit burst counter through the four words of the aligned line, in either linear or interleaved order. If no strobe and no advance are present, the current address is held.

`out_en` gates the read drive combinationally, with no clock involved. `sleep` parks the device without losing its contents. `rdata_drive` is the drive-enable that a pad ring turns into a tri-state buffer; while it is low, `rdata` reads zero.

All pins are plain control and data pins with a fixed timing relation to the clock. There is no valid/ready handshake and no back-pressure: every edge is accepted or ignored by the rules below.

Top module: `sburst_sram`

## Requirements
- R1: An edge with `proc_start` and all three selects high opens a read of `addr`. After that edge, `rdata` equals the stored word and `rdata_drive` is 1.
- R2: With `ilv_mode`=0, each edge with `advance` high and no strobe moves the low two address bits to (first + count) mod 4, where count is 1, 2, 3 and then 0. The wrap returns to the starting word, and address bits above bit 1 never change during the burst.
- R3: With `ilv_mode`=1, the low two address bits follow first XOR count for count 1, 2, 3 and then 0.
- R4: A `proc_start` edge never writes, even when `write_all` or `byte_write` is high.
- R5: `proc_start` is ignored while `sel_main` is 0. The open access and `rdata` are unchanged.
- R6: A `ctrl_start` edge with all selects high writes when `write_all` is 1, or when `byte_write` is 1 and any `lane_en` bit is set; otherwise it opens a read. A strobe that is taken (a `ctrl_start`, or a `proc_start` with `sel_main` high) while `sel_a` or `sel_b` is 0 closes the access, so `rdata_drive` is 0 after the edge.
- R7: When `byte_write`=1 and `write_all`=0, lane i (bits 9i+8..9i) is written only if `lane_en[i]` is 1. `write_all`=1 writes all four lanes and ignores `lane_en`.
- R8: `rdata_drive` is 0 at once, with no clock edge, while `out_en` is 0. It is also 0 for the cycle after any write edge.
- R9: While `sleep` is 1, `rdata_drive` is 0 at once and every strobe, advance and write is ignored. After `sleep` falls, the first two edges are also ignored and the third edge is served. Stored data is kept throughout.
- R10: After reset, no access is open and `rdata_drive` is 0; `advance` alone does not open one.
- R11: When `proc_start` (with `sel_main`=1) and `ctrl_start` arrive on the same edge, the processor strobe wins and a read is opened.
- R12: An edge with an open access, no strobe and no advance keeps the address. With no write enables, the word read stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of control state (not of storage) |
| addr | input | ADDR_W | Word address, taken on a start strobe |
| proc_start | input | 1 | Processor start strobe, read only |
| ctrl_start | input | 1 | Controller start strobe, read or write |
| advance | input | 1 | Step the burst counter |
| sel_main | input | 1 | Primary select, also qualifies `proc_start` |
| sel_a | input | 1 | Secondary select |
| sel_b | input | 1 | Tertiary select |
| write_all | input | 1 | Write all four lanes |
| byte_write | input | 1 | Qualifies `lane_en` |
| lane_en | input | BYTES | Per-lane write enables |
| wdata | input | BYTES*BYTE_W | Write data |
| ilv_mode | input | 1 | 0 linear burst, 1 interleaved burst |
| out_en | input | 1 | Asynchronous read drive gate |
| sleep | input | 1 | Low-power park, contents kept |
| rdata | output | BYTES*BYTE_W | Read word, zero while not driven |
| rdata_drive | output | 1 | Drive enable for the read bus |

## Verification
A wrong burst count or line base shows up in the very next cycle after an `advance` edge: `rdata` shows a neighbouring word of the line, or a word from another line. A stuck open/closed access flag shows up as `rdata_drive` having the wrong level on the edge that follows a strobe or a deselect. A mis-counted wake-up delay moves the first served strobe after `sleep` one edge earlier or later. A bad lane mask only becomes visible at the next read of the written word, so every masked write is read back immediately.

// File: rtl/sburst_pkg.sv
package sburst_pkg;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_START,
    ACT_STEP,
    ACT_HOLD,
    ACT_DESEL
  } act_e;

  // word position inside a four-word line for a given burst count
  function automatic logic [1:0] line_pos(input logic [1:0] first,
                                          input logic [1:0] step,
                                          input logic       ilv);
    line_pos = ilv ? (first ^ step) : (first + step);
  endfunction

endpackage

// File: rtl/sburst_ctl.sv
module sburst_ctl
  import sburst_pkg::*;
#(
  parameter int BYTES    = 4,
  parameter int WAKE_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             proc_start,
  input  logic             ctrl_start,
  input  logic             advance,
  input  logic             sel_main,
  input  logic             sel_a,
  input  logic             sel_b,
  input  logic             write_all,
  input  logic             byte_write,
  input  logic [BYTES-1:0] lane_en,
  input  logic             sleep,
  output act_e             act,
  output logic [BYTES-1:0] we_lanes,
  output logic             awake,
  output logic             line_act,
  output logic             wr_cycle
);

  localparam int WK_W = $clog2(WAKE_CYC + 1);

  logic [WK_W-1:0] wake_q;
  logic            all_sel;
  logic            wr_req;
  logic            do_wr;
  logic            proc_go;

  assign all_sel = sel_main & sel_a & sel_b;
  assign wr_req  = write_all | (byte_write & (|lane_en));
  assign proc_go = proc_start & sel_main;
  assign awake   = !sleep && (wake_q == '0);

  always_comb begin
    act   = ACT_NONE;
    do_wr = 1'b0;
    if (awake) begin
      if (proc_go) begin
        act = all_sel ? ACT_START : ACT_DESEL;
      end else if (ctrl_start) begin
        act   = all_sel ? ACT_START : ACT_DESEL;
        do_wr = all_sel & wr_req;
      end else if (line_act) begin
        act   = advance ? ACT_STEP : ACT_HOLD;
        do_wr = wr_req;
      end
    end
  end

  for (genvar g = 0; g < BYTES; g++) begin : g_lane_we
    assign we_lanes[g] = do_wr & (write_all | (byte_write & lane_en[g]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_act <= 1'b0;
      wr_cycle <= 1'b0;
      wake_q   <= '0;
    end else if (sleep) begin
      line_act <= 1'b0;
      wr_cycle <= 1'b0;
      wake_q   <= WK_W'(WAKE_CYC);
    end else if (wake_q != '0) begin
      wake_q   <= wake_q - 1'b1;
      wr_cycle <= 1'b0;
    end else begin
      wr_cycle <= do_wr;
      if (act == ACT_START) line_act <= 1'b1;
      else if (act == ACT_DESEL) line_act <= 1'b0;
    end
  end

endmodule

// File: rtl/sburst_seq.sv
module sburst_seq
  import sburst_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  act_e              act,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ilv_mode,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [ADDR_W-1:0] nxt_addr
);

  localparam int HI_W = ADDR_W - 2;

  logic [HI_W-1:0] hi_q;
  logic [1:0]      first_q;
  logic [1:0]      cnt_q;
  logic [1:0]      cnt_inc;

  assign cnt_inc  = cnt_q + 2'd1;
  assign cur_addr = {hi_q, line_pos(first_q, cnt_q, ilv_mode)};

  always_comb begin
    case (act)
      ACT_START: nxt_addr = addr;
      ACT_STEP:  nxt_addr = {hi_q, line_pos(first_q, cnt_inc, ilv_mode)};
      default:   nxt_addr = cur_addr;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q    <= '0;
      first_q <= '0;
      cnt_q   <= '0;
    end else if (act == ACT_START) begin
      hi_q    <= addr[ADDR_W-1:2];
      first_q <= addr[1:0];
      cnt_q   <= '0;
    end else if (act == ACT_STEP) begin
      cnt_q   <= cnt_inc;
    end
  end

endmodule

// File: rtl/sburst_array.sv
module sburst_array #(
  parameter int ADDR_W = 8,
  parameter int BYTES  = 4,
  parameter int BYTE_W = 9
) (
  input  logic                    clk,
  input  logic [BYTES-1:0]        we_lanes,
  input  logic [ADDR_W-1:0]       waddr,
  input  logic [BYTES*BYTE_W-1:0] wdata,
  input  logic [ADDR_W-1:0]       raddr,
  output logic [BYTES*BYTE_W-1:0] rword
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    logic [BYTE_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
      if (we_lanes[g]) store[waddr] <= wdata[g*BYTE_W +: BYTE_W];
    end

    assign rword[g*BYTE_W +: BYTE_W] = store[raddr];
  end

endmodule

// File: rtl/sburst_sram.sv
module sburst_sram
  import sburst_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int BYTES    = 4,
  parameter int BYTE_W   = 9,
  parameter int WAKE_CYC = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    proc_start,
  input  logic                    ctrl_start,
  input  logic                    advance,
  input  logic                    sel_main,
  input  logic                    sel_a,
  input  logic                    sel_b,
  input  logic                    write_all,
  input  logic                    byte_write,
  input  logic [BYTES-1:0]        lane_en,
  input  logic [BYTES*BYTE_W-1:0] wdata,
  input  logic                    ilv_mode,
  input  logic                    out_en,
  input  logic                    sleep,
  output logic [BYTES*BYTE_W-1:0] rdata,
  output logic                    rdata_drive
);

  localparam int DATA_W = BYTES * BYTE_W;

  act_e              act;
  logic [BYTES-1:0]  we_lanes;
  logic              awake;
  logic              line_act;
  logic              wr_cycle;
  logic [ADDR_W-1:0] cur_addr;
  logic [ADDR_W-1:0] nxt_addr;
  logic [DATA_W-1:0] rword;

  sburst_ctl #(.BYTES(BYTES), .WAKE_CYC(WAKE_CYC)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .proc_start (proc_start),
    .ctrl_start (ctrl_start),
    .advance    (advance),
    .sel_main   (sel_main),
    .sel_a      (sel_a),
    .sel_b      (sel_b),
    .write_all  (write_all),
    .byte_write (byte_write),
    .lane_en    (lane_en),
    .sleep      (sleep),
    .act        (act),
    .we_lanes   (we_lanes),
    .awake      (awake),
    .line_act   (line_act),
    .wr_cycle   (wr_cycle)
  );

  sburst_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .act      (act),
    .addr     (addr),
    .ilv_mode (ilv_mode),
    .cur_addr (cur_addr),
    .nxt_addr (nxt_addr)
  );

  sburst_array #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_arr (
    .clk      (clk),
    .we_lanes (we_lanes),
    .waddr    (nxt_addr),
    .wdata    (wdata),
    .raddr    (cur_addr),
    .rword    (rword)
  );

  // drive gate is combinational in out_en and sleep
  assign rdata_drive = out_en & line_act & !wr_cycle & !sleep;
  assign rdata       = rdata_drive ? rword : '0;

endmodule

// File: rtl/sburst_sram_chk.sv
module sburst_sram_chk #(
  parameter int ADDR_W = 8,
  parameter int BYTES  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              proc_start,
  input logic              ctrl_start,
  input logic              advance,
  input logic              sel_main,
  input logic              sel_a,
  input logic              sel_b,
  input logic              ilv_mode,
  input logic              out_en,
  input logic              sleep,
  input logic              rdata_drive,
  input logic              awake,
  input logic              line_act,
  input logic [BYTES-1:0]  we_lanes,
  input logic [ADDR_W-1:0] cur_addr
);

  assert_outen_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |-> !rdata_drive)
    else $error("drive active with out_en low");

  assert_sleep_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !rdata_drive)
    else $error("drive active during sleep");

  assert_proc_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (awake && proc_start && sel_main) |-> (we_lanes == '0))
    else $error("processor strobe wrote");

  assert_deselect_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (awake && ctrl_start && !(proc_start && sel_main) && !(sel_main && sel_a && sel_b))
      |=> !line_act)
    else $error("partial select left access open");

  assert_hold_addr_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (awake && line_act && !proc_start && !ctrl_start && !advance) |=> $stable(cur_addr))
    else $error("address moved on hold");

  assert_upper_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (awake && line_act && advance && !proc_start && !ctrl_start)
      |=> (cur_addr[ADDR_W-1:2] == $past(cur_addr[ADDR_W-1:2])))
    else $error("burst left its line");

  assert_linear_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (awake && line_act && advance && !proc_start && !ctrl_start && !ilv_mode)
      |=> ((cur_addr[1:0] - $past(cur_addr[1:0])) == 2'd1))
    else $error("linear step wrong");

endmodule

bind sburst_sram sburst_sram_chk #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .proc_start  (proc_start),
  .ctrl_start  (ctrl_start),
  .advance     (advance),
  .sel_main    (sel_main),
  .sel_a       (sel_a),
  .sel_b       (sel_b),
  .ilv_mode    (ilv_mode),
  .out_en      (out_en),
  .sleep       (sleep),
  .rdata_drive (rdata_drive),
  .awake       (awake),
  .line_act    (line_act),
  .we_lanes    (we_lanes),
  .cur_addr    (cur_addr)
);

// File: tb/sburst_sram_bench.sv
module sburst_sram_bench;

  localparam int CLK_NS = 10;
  localparam int AW = 8;
  localparam int NB = 4;
  localparam int BW = 9;
  localparam int DW = NB * BW;

  // {address, word}
  localparam logic [AW+DW-1:0] VEC [8] = '{
    {8'h40, 36'h1_0203_0405}, {8'h41, 36'h2_1111_2222},
    {8'h42, 36'h3_3333_4444}, {8'h43, 36'h4_5555_6666},
    {8'h44, 36'h5_7777_8888}, {8'h45, 36'h6_9999_AAAA},
    {8'h46, 36'h7_BBBB_CCCC}, {8'h47, 36'h8_DDDD_EEEE}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic proc_start = 0, ctrl_start = 0, advance = 0;
  logic sel_main = 1, sel_a = 1, sel_b = 1;
  logic write_all = 0, byte_write = 0;
  logic [NB-1:0] lane_en = '0;
  logic [DW-1:0] wdata = '0;
  logic ilv_mode = 0, out_en = 1, sleep = 0;
  logic [DW-1:0] rdata;
  logic          rdata_drive;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_NS/2) clk = ~clk;

  sburst_sram u_sburst_sram (
    .clk(clk), .rst_n(rst_n), .addr(addr), .proc_start(proc_start),
    .ctrl_start(ctrl_start), .advance(advance), .sel_main(sel_main),
    .sel_a(sel_a), .sel_b(sel_b), .write_all(write_all),
    .byte_write(byte_write), .lane_en(lane_en), .wdata(wdata),
    .ilv_mode(ilv_mode), .out_en(out_en), .sleep(sleep),
    .rdata(rdata), .rdata_drive(rdata_drive)
  );

  function automatic logic [DW-1:0] dval(input int i);
    dval = VEC[i][DW-1:0];
  endfunction

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_w,
                                          input logic [DW-1:0] new_w,
                                          input logic [NB-1:0] ln);
    merge = old_w;
    for (int i = 0; i < NB; i++)
      if (ln[i]) merge[i*BW +: BW] = new_w[i*BW +: BW];
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act_v, input logic [DW-1:0] exp_v);
    total++;
    if (act_v !== exp_v) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act_v, exp_v);
    end
  endtask

  task automatic set_idle();
    proc_start = 0; ctrl_start = 0; advance = 0;
    sel_main = 1; sel_a = 1; sel_b = 1;
    write_all = 0; byte_write = 0; lane_en = '0;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic rd_start(input logic [AW-1:0] a);
    @(negedge clk); set_idle(); addr = a; proc_start = 1; tick();
  endtask

  task automatic wr_ctrl(input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input logic wa, input logic bwe, input logic [NB-1:0] ln);
    @(negedge clk); set_idle(); addr = a; wdata = d; ctrl_start = 1;
    write_all = wa; byte_write = bwe; lane_en = ln; tick();
  endtask

  task automatic step_adv();
    @(negedge clk); set_idle(); advance = 1; tick();
  endtask

  task automatic hold_one();
    @(negedge clk); set_idle(); tick();
  endtask

  initial begin
    logic [DW-1:0] w7;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    tick();
    chk("R10 drive after reset", {35'd0, rdata_drive}, 36'd0);
    step_adv();
    chk("R10 advance alone opens nothing", {35'd0, rdata_drive}, 36'd0);

    // table walk: fill then read back
    for (int i = 0; i < 8; i++) begin
      wr_ctrl(VEC[i][AW+DW-1:DW], dval(i), 1'b1, 1'b0, '0);
      chk("R8 no drive after write edge", {35'd0, rdata_drive}, 36'd0);
    end
    for (int i = 0; i < 8; i++) begin
      rd_start(VEC[i][AW+DW-1:DW]);
      chk("R1 flow-through read", rdata, dval(i));
    end

    // linear burst from word 1 of line 0x40
    rd_start(8'h41);
    chk("R2 linear first", rdata, dval(1));
    step_adv(); chk("R2 linear +1", rdata, dval(2));
    step_adv(); chk("R2 linear +2", rdata, dval(3));
    step_adv(); chk("R2 linear +3 wraps low bits", rdata, dval(0));
    step_adv(); chk("R2 linear returns to start", rdata, dval(1));
    hold_one(); chk("R12 hold keeps word", rdata, dval(1));

    // interleaved burst from word 2
    @(negedge clk); ilv_mode = 1;
    rd_start(8'h42);
    chk("R3 interleaved first", rdata, dval(2));
    step_adv(); chk("R3 interleaved 2^1", rdata, dval(3));
    step_adv(); chk("R3 interleaved 2^2", rdata, dval(0));
    step_adv(); chk("R3 interleaved 2^3", rdata, dval(1));
    step_adv(); chk("R3 interleaved back to start", rdata, dval(2));
    @(negedge clk); ilv_mode = 0;

    // R5: processor strobe ignored while sel_main low
    rd_start(8'h44);
    @(negedge clk); set_idle(); sel_main = 0; proc_start = 1; addr = 8'h45; tick();
    chk("R5 ignored strobe keeps word", rdata, dval(4));

    // R4: processor strobe with write enables is a read
    @(negedge clk); set_idle(); proc_start = 1; addr = 8'h44;
    write_all = 1; byte_write = 1; lane_en = '1; wdata = 36'hF_FFFF_FFFF; tick();
    chk("R4 proc strobe reads", {35'd0, rdata_drive}, 36'd1);
    hold_one();
    chk("R4 word not overwritten", rdata, dval(4));

    // R11: both strobes, processor wins
    @(negedge clk); set_idle(); proc_start = 1; ctrl_start = 1; addr = 8'h46;
    write_all = 1; wdata = 36'h0_DEAD_BEEF; tick();
    chk("R11 processor strobe wins", rdata, dval(6));

    // R7: lane-masked write then global write
    wr_ctrl(8'h47, 36'h1_2345_6789, 1'b0, 1'b1, 4'b0101);
    rd_start(8'h47);
    w7 = merge(dval(7), 36'h1_2345_6789, 4'b0101);
    chk("R7 lanes 0 and 2 only", rdata, w7);
    wr_ctrl(8'h47, 36'hA_5A5A_5A5A, 1'b1, 1'b0, 4'b0000);
    rd_start(8'h47);
    chk("R7 write_all ignores lane_en", rdata, 36'hA_5A5A_5A5A);

    // R6: ctrl strobe without byte_write is a read
    @(negedge clk); set_idle(); ctrl_start = 1; addr = 8'h47;
    lane_en = '1; wdata = 36'h0; tick();
    chk("R6 ctrl read opens drive", {35'd0, rdata_drive}, 36'd1);
    chk("R6 ctrl read keeps data", rdata, 36'hA_5A5A_5A5A);

    // R6: partial select closes the access
    @(negedge clk); set_idle(); ctrl_start = 1; sel_b = 0; addr = 8'h40; tick();
    chk("R6 partial select deselects", {35'd0, rdata_drive}, 36'd0);
    step_adv();
    chk("R6 advance after deselect", {35'd0, rdata_drive}, 36'd0);

    // R8: asynchronous output gate
    rd_start(8'h40);
    @(negedge clk); set_idle(); out_en = 0; #1;
    chk("R8 out_en low drive", {35'd0, rdata_drive}, 36'd0);
    chk("R8 out_en low data", rdata, 36'd0);
    out_en = 1; #1;
    chk("R8 out_en restored", rdata, dval(0));

    // R9: sleep, ignored write, two-edge recovery
    @(negedge clk); set_idle(); sleep = 1; #1;
    chk("R9 sleep drops drive at once", {35'd0, rdata_drive}, 36'd0);
    ctrl_start = 1; write_all = 1; addr = 8'h40; wdata = 36'h0_0BAD_0BAD;
    tick();
    @(negedge clk); set_idle(); sleep = 0; proc_start = 1; addr = 8'h40;
    tick();
    chk("R9 first edge after wake ignored", {35'd0, rdata_drive}, 36'd0);
    tick();
    chk("R9 second edge after wake ignored", {35'd0, rdata_drive}, 36'd0);
    tick();
    chk("R9 third edge served", {35'd0, rdata_drive}, 36'd1);
    chk("R9 contents kept, sleep write ignored", rdata, dval(0));

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule